// File: doc/BRIEF.md
# Background Multiply-Divide Unit with Result Register Pair

This block performs 32-bit integer multiplication and division next to a processor pipeline without holding it up. A command carries an operation code and two operands. Once the unit accepts it, the unit runs on its own for a fixed number of cycles. The results land in a private pair of result registers, HI and LO, which are kept apart from the general register file. The pipeline can keep issuing unrelated work while `busy` is high. Only an attempt to read HI or LO during that time is stalled.

A multiply puts the upper half of the 64-bit product into HI and the lower half into LO. A divide puts the quotient into LO and the remainder into HI. Both operations exist in signed (two's complement) and unsigned forms. Two direct-write commands copy an operand straight into HI or into LO, so that saved state can be restored after an exception. A command offered while the unit is busy is held off through a valid/ready handshake and is never lost. A direct write that waits behind a running operation therefore lands after that operation and overwrites its result.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, HI and LO are zero, `busy` is low and `cmd_ready` is high.
- R2: `cmd_op`=1 (unsigned multiply) leaves the upper 32 bits of the unsigned 64-bit product of `cmd_a` and `cmd_b` in HI and the lower 32 bits in LO.
- R3: `cmd_op`=0 (signed multiply) treats both operands as two's complement and leaves the signed 64-bit product split the same way: upper half in HI, lower half in LO.
- R4: `cmd_op`=3 (unsigned divide) leaves `cmd_a / cmd_b` in LO and `cmd_a mod cmd_b` in HI.
- R5: `cmd_op`=2 (signed divide) truncates the quotient toward zero, and the remainder carries the sign of the dividend. The most negative value divided by -1 yields quotient 0x80000000 and remainder 0.
- R6: A divide by zero, signed or unsigned, does not trap. It leaves all ones in LO and the unchanged dividend in HI.
- R7: A multiply or divide holds `busy` high for exactly 32 cycles after the accepting edge. HI and LO do not change while it runs, and the results are readable in the first cycle in which `busy` is low.
- R8: `cmd_ready` is low whenever `busy` is high. A command held on `cmd_valid` during that time is accepted afterwards, not dropped.
- R9: `rd_data` returns HI when `rd_sel`=1 and LO when `rd_sel`=0. `rd_stall` equals `rd_req` while `busy` is high and is low otherwise.
- R10: `cmd_op`=4 copies `cmd_a` into HI and `cmd_op`=5 copies it into LO, one cycle after acceptance. `busy` stays low and the other register is unchanged.
- R11: A direct write offered while an operation runs is applied after that operation finishes, so its value replaces that operation's result in its register.
- R12: `cmd_op` values 6 and 7 are accepted and change neither HI nor LO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can accept a command this cycle |
| cmd_op | input | 3 | Operation code (see R2 to R12) |
| cmd_a | input | 32 | First operand: multiplicand, dividend, or direct-write value |
| cmd_b | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | An operation is in flight |
| rd_req | input | 1 | Read of HI or LO requested |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_stall | output | 1 | Read must be retried: an operation is unfinished |
| rd_data | output | 32 | Selected result register |

## Verification
The bound checker watches the timing rules on every cycle. It confirms that `cmd_ready` is held low while busy and that reads stall exactly while busy. It also confirms that every busy period lasts 32 cycles, that HI and LO stay frozen during a run, that direct writes land in the following cycle, and that the unused codes leave both registers alone. The arithmetic cannot be seen that way: the product, quotient, remainder and divide-by-zero values are checked only by the bench's vectors and directed scenarios. So is the ordering in which a held direct write overrides a finished result.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   typedef enum logic [2:0] {
      OP_MUL_S = 3'd0,
      OP_MUL_U = 3'd1,
      OP_DIV_S = 3'd2,
      OP_DIV_U = 3'd3,
      OP_TO_HI = 3'd4,
      OP_TO_LO = 3'd5,
      OP_NONE6 = 3'd6,
      OP_NONE7 = 3'd7
   } mdu_op_e;
endpackage

// File: rtl/mdu_mul_seq.sv
// Shift-and-add multiplier on unsigned magnitudes, one multiplier bit per step.
module mdu_mul_seq #(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic [WIDTH-1:0]   mcand_in,
   input  logic [WIDTH-1:0]   mplier_in,
   output logic [2*WIDTH-1:0] prod_nxt
);
   localparam int PW = 2 * WIDTH;

   logic [PW-1:0]    acc_q;
   logic [WIDTH-1:0] mcand_q;
   logic [WIDTH:0]   part_sum;

   // upper half plus multiplicand when the current low bit is set
   assign part_sum = {1'b0, acc_q[PW-1:WIDTH]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
   assign prod_nxt = {part_sum, acc_q[WIDTH-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         mcand_q <= '0;
      end else if (load) begin
         acc_q   <= {{WIDTH{1'b0}}, mplier_in};
         mcand_q <= mcand_in;
      end else if (step) begin
         acc_q   <= prod_nxt;
      end
   end
endmodule

// File: rtl/mdu_div_seq.sv
// Restoring divider on unsigned magnitudes, one quotient bit per step.
module mdu_div_seq #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] dvd_in,
   input  logic [WIDTH-1:0] dsr_in,
   output logic [WIDTH-1:0] quo_nxt,
   output logic [WIDTH-1:0] rem_nxt
);
   logic [WIDTH-1:0] rem_q, quo_q, dsr_q;
   logic [WIDTH:0]   shifted, trial;

   assign shifted = {rem_q, quo_q[WIDTH-1]};
   assign trial   = shifted - {1'b0, dsr_q};

   always_comb begin
      if (!trial[WIDTH]) begin
         rem_nxt = trial[WIDTH-1:0];
         quo_nxt = {quo_q[WIDTH-2:0], 1'b1};
      end else begin
         rem_nxt = shifted[WIDTH-1:0];
         quo_nxt = {quo_q[WIDTH-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dsr_q <= '0;
      end else if (load) begin
         rem_q <= '0;
         quo_q <= dvd_in;
         dsr_q <= dsr_in;
      end else if (step) begin
         rem_q <= rem_nxt;
         quo_q <= quo_nxt;
      end
   end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
   import mdu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [2:0]       cmd_op,
   input  logic [WIDTH-1:0] cmd_a,
   input  logic [WIDTH-1:0] cmd_b,
   output logic             busy,
   input  logic             rd_req,
   input  logic             rd_sel,
   output logic             rd_stall,
   output logic [WIDTH-1:0] rd_data
);
   localparam int CW = $clog2(WIDTH);
   localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

   if (WIDTH < 4) begin : g_bad_width
      $error("mdu_hilo: WIDTH must be at least 4");
   end
   if ((1 << CW) != WIDTH) begin : g_bad_pow2
      $error("mdu_hilo: WIDTH must be a power of two");
   end

   mdu_op_e op_in;
   logic    is_mul, is_div, is_sgn, fire, start, last;

   assign op_in  = mdu_op_e'(cmd_op);
   assign is_mul = (op_in == OP_MUL_S) || (op_in == OP_MUL_U);
   assign is_div = (op_in == OP_DIV_S) || (op_in == OP_DIV_U);
   assign is_sgn = (op_in == OP_MUL_S) || (op_in == OP_DIV_S);

   logic             busy_q, run_div_q, neg_x_q, neg_d_q, div0_q;
   logic [CW-1:0]    cnt_q;
   logic [WIDTH-1:0] dvd_q, hi_q, lo_q;

   assign cmd_ready = !busy_q;
   assign fire      = cmd_valid && cmd_ready;
   assign start     = fire && (is_mul || is_div);
   assign last      = busy_q && (cnt_q == LAST_CNT);

   // operand magnitudes: index 0 is cmd_a, index 1 is cmd_b
   logic [1:0][WIDTH-1:0] opnd, mag;
   logic [1:0]            neg;
   assign opnd[0] = cmd_a;
   assign opnd[1] = cmd_b;
   for (genvar gi = 0; gi < 2; gi++) begin : g_mag
      assign neg[gi] = is_sgn && opnd[gi][WIDTH-1];
      assign mag[gi] = neg[gi] ? (~opnd[gi] + 1'b1) : opnd[gi];
   end

   logic [2*WIDTH-1:0] prod_nxt, prod_fix;
   logic [WIDTH-1:0]   quo_nxt, rem_nxt, quo_fix, rem_fix;

   mdu_mul_seq #(.WIDTH(WIDTH)) u_mul (
      .clk(clk), .rst_n(rst_n), .load(start), .step(busy_q),
      .mcand_in(mag[0]), .mplier_in(mag[1]), .prod_nxt(prod_nxt)
   );

   mdu_div_seq #(.WIDTH(WIDTH)) u_div (
      .clk(clk), .rst_n(rst_n), .load(start), .step(busy_q),
      .dvd_in(mag[0]), .dsr_in(mag[1]), .quo_nxt(quo_nxt), .rem_nxt(rem_nxt)
   );

   // sign restoration on the final step
   assign prod_fix = neg_x_q ? (~prod_nxt + 1'b1) : prod_nxt;
   assign quo_fix  = div0_q ? '1 : (neg_x_q ? (~quo_nxt + 1'b1) : quo_nxt);
   assign rem_fix  = div0_q ? dvd_q : (neg_d_q ? (~rem_nxt + 1'b1) : rem_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         run_div_q <= 1'b0;
         neg_x_q   <= 1'b0;
         neg_d_q   <= 1'b0;
         div0_q    <= 1'b0;
         dvd_q     <= '0;
      end else if (start) begin
         busy_q    <= 1'b1;
         cnt_q     <= '0;
         run_div_q <= is_div;
         neg_x_q   <= neg[0] ^ neg[1];
         neg_d_q   <= neg[0];
         div0_q    <= is_div && (cmd_b == '0);
         dvd_q     <= cmd_a;
      end else if (last) begin
         busy_q    <= 1'b0;
      end else if (busy_q) begin
         cnt_q     <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (last) begin
         hi_q <= run_div_q ? rem_fix : prod_fix[2*WIDTH-1:WIDTH];
         lo_q <= run_div_q ? quo_fix : prod_fix[WIDTH-1:0];
      end else if (fire && op_in == OP_TO_HI) begin
         hi_q <= cmd_a;
      end else if (fire && op_in == OP_TO_LO) begin
         lo_q <= cmd_a;
      end
   end

   assign busy     = busy_q;
   assign rd_stall = rd_req && busy_q;
   assign rd_data  = rd_sel ? hi_q : lo_q;
endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [2:0]       cmd_op,
   input logic [WIDTH-1:0] cmd_a,
   input logic             busy,
   input logic             rd_req,
   input logic             rd_stall,
   input logic [WIDTH-1:0] hi_q,
   input logic [WIDTH-1:0] lo_q
);
   localparam int RW = $clog2(WIDTH + 2);
   logic [RW-1:0] run_q;
   logic          acc;

   assign acc = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   p_ready_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cmd_ready);
   p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && busy) |-> rd_stall);
   p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_stall);
   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == RW'(WIDTH)));
   p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RW'(WIDTH)));
   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op < 3'd4) |=> busy);
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || ($stable(hi_q) && $stable(lo_q))));
   p_to_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd4) |=> (hi_q == $past(cmd_a) && $stable(lo_q) && !busy));
   p_to_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd5) |=> (lo_q == $past(cmd_a) && $stable(hi_q) && !busy));
   p_unused_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op >= 3'd6) |=> ($stable(hi_q) && $stable(lo_q) && !busy));
endmodule

bind mdu_hilo mdu_hilo_chk #(.WIDTH(WIDTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_op(cmd_op), .cmd_a(cmd_a), .busy(busy), .rd_req(rd_req),
   .rd_stall(rd_stall), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_mdu_hilo.sv
`timescale 1ns/1ps
module test_mdu_hilo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = '0;
   logic [31:0] cmd_a = '0, cmd_b = '0;
   logic        busy;
   logic        rd_req = 1'b0, rd_sel = 1'b0;
   logic        rd_stall;
   logic [31:0] rd_data;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   mdu_hilo i_mdu_hilo (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
      .rd_req(rd_req), .rd_sel(rd_sel), .rd_stall(rd_stall), .rd_data(rd_data)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  op;
      logic [31:0] a, b, ehi, elo;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001}, // R2
      '{4'd2,  3'd1, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'h0000_0000}, // R2
      '{4'd3,  3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001}, // R3
      '{4'd3,  3'd0, 32'hFFFF_FFFE, 32'h0000_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFA}, // R3
      '{4'd3,  3'd0, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000}, // R3
      '{4'd4,  3'd3, 32'd100,       32'd7,         32'd2,         32'd14},        // R4
      '{4'd4,  3'd3, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_000F, 32'h0FFF_FFFF}, // R4
      '{4'd5,  3'd2, 32'hFFFF_FFF9, 32'd2,         32'hFFFF_FFFF, 32'hFFFF_FFFD}, // R5
      '{4'd5,  3'd2, 32'd7,         32'hFFFF_FFFE, 32'd1,         32'hFFFF_FFFD}, // R5
      '{4'd5,  3'd2, 32'hFFFF_FFF8, 32'hFFFF_FFFD, 32'hFFFF_FFFE, 32'd2},         // R5
      '{4'd5,  3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0,         32'h8000_0000}, // R5
      '{4'd6,  3'd3, 32'd5,         32'd0,         32'd5,         32'hFFFF_FFFF}, // R6
      '{4'd6,  3'd2, 32'hFFFF_FFFB, 32'd0,         32'hFFFF_FFFB, 32'hFFFF_FFFF}  // R6
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Offer a command at a falling edge and hold it until an edge accepts it.
   task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
      forever begin
         logic rdy;
         rdy = cmd_ready;
         @(negedge clk);
         if (rdy) break;
      end
      cmd_valid = 1'b0;
   endtask

   // Sample at the current falling edge; rd_data is a direct register view.
   task automatic read_reg(input logic sel, output logic [31:0] val, output logic stl);
      rd_req = 1'b1; rd_sel = sel;
      #0.5;
      val = rd_data; stl = rd_stall;
      rd_req = 1'b0;
   endtask

   // Counts busy falling-edge samples; the first one is the current edge.
   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      #200000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v, h0, l0;
      logic        s;
      int          cyc;

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy", {31'd0, busy}, 32'd0);
      check("R1", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
      read_reg(1'b1, v, s); check("R1", "HI", v, 32'd0);
      read_reg(1'b0, v, s); check("R1", "LO", v, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = $sformatf("R%0d", VEC[i].req);
         issue(VEC[i].op, VEC[i].a, VEC[i].b);
         // issue returns one falling edge after acceptance
         wait_idle(cyc);
         check("R7", "busy cycles", cyc, 32'd32);
         read_reg(1'b1, v, s); check(rq, $sformatf("HI vec %0d", i), v, VEC[i].ehi);
         read_reg(1'b0, v, s); check(rq, $sformatf("LO vec %0d", i), v, VEC[i].elo);
      end

      // R9: read interlock during a run, value frozen (R7), no stall afterwards
      issue(3'd1, 32'd3, 32'd5);
      check("R8", "ready while busy", {31'd0, cmd_ready}, 32'd0);
      read_reg(1'b0, v, s);
      check("R9", "stall while busy", {31'd0, s}, 32'd1);
      check("R7", "LO frozen while busy", v, 32'hFFFF_FFFF);
      wait_idle(cyc);
      read_reg(1'b0, v, s);
      check("R9", "no stall idle", {31'd0, s}, 32'd0);
      check("R2", "LO 3*5", v, 32'd15);
      read_reg(1'b1, v, s);
      check("R9", "HI select", v, 32'd0);

      // R10: direct writes while idle
      issue(3'd5, 32'h1234_5678, 32'd0);
      check("R10", "busy after write", {31'd0, busy}, 32'd0);
      read_reg(1'b0, v, s); check("R10", "LO written", v, 32'h1234_5678);
      read_reg(1'b1, v, s); check("R10", "HI kept", v, 32'd0);
      issue(3'd4, 32'hCAFE_0001, 32'd0);
      read_reg(1'b1, v, s); check("R10", "HI written", v, 32'hCAFE_0001);
      read_reg(1'b0, v, s); check("R10", "LO kept", v, 32'h1234_5678);

      // R12: unused codes leave both registers alone
      issue(3'd6, 32'hAAAA_AAAA, 32'h5555_5555);
      issue(3'd7, 32'hBBBB_BBBB, 32'h1);
      read_reg(1'b1, v, s); check("R12", "HI unchanged", v, 32'hCAFE_0001);
      read_reg(1'b0, v, s); check("R12", "LO unchanged", v, 32'h1234_5678);

      // R8 / R11: direct write held behind a multiply lands afterwards
      issue(3'd1, 32'd6, 32'd7);
      issue(3'd4, 32'h0000_DEAD, 32'd0);
      check("R8", "busy after held write", {31'd0, busy}, 32'd0);
      read_reg(1'b1, v, s); check("R11", "HI overridden", v, 32'h0000_DEAD);
      read_reg(1'b0, v, s); check("R11", "LO from multiply", v, 32'd42);

      // R11: held LO write behind a divide
      issue(3'd3, 32'd50, 32'd8);
      issue(3'd5, 32'h0000_BEEF, 32'd0);
      read_reg(1'b1, v, s); check("R11", "HI remainder", v, 32'd2);
      read_reg(1'b0, v, s); check("R11", "LO overridden", v, 32'h0000_BEEF);

      // R1: asynchronous reset mid-run clears state
      issue(3'd0, 32'd9, 32'd9);
      rst_n = 1'b0;
      #0.5;
      read_reg(1'b1, h0, s);
      read_reg(1'b0, l0, s);
      check("R1", "busy after reset", {31'd0, busy}, 32'd0);
      check("R1", "HI after reset", h0, 32'd0);
      check("R1", "LO after reset", l0, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule